// File: doc/BRIEF.md
# Exception Status and Cause Unit

This unit holds the privileged machine state that a small RISC core needs to handle traps. It keeps a status register, a cause register, an exception return address register and a faulting-address register. It updates them when a synchronous exception, a system call, a hardware interrupt or a return-from-exception occurs. The pipeline reports a trap request with a type code and the address of the instruction in flight. The unit then raises a trap-taken strobe together with the single fixed handler address and saves the context the handler needs.

The mode and interrupt-enable bits sit in a three-level hardware stack inside the status register. Every trap pushes the stack and enters kernel mode with interrupts disabled. A return pops it, so a handler that is itself interrupted by a higher level can later resume with its own context intact. Privileged software reads all four registers on dedicated outputs. It writes them through a single write port, and that port is refused in user mode.

Top module: `exc_status_unit`

## Requirements
- R1: After reset, all four registers read as zero, which means kernel mode with interrupts disabled, all masks clear and no interrupt pending. `kernelMode` is then 1.
- R2: Status bit 0 is the current interrupt enable (1 = enabled). Bit 1 is the current mode (0 = kernel, 1 = user). Bits 3:2 hold the previous pair and bits 5:4 the old pair. Status bits 10+i are the mask for interrupt line i. `kernelMode` is the inverse of status bit 1.
- R3: On every trap the stack shifts up, with bits 3:0 moving into bits 5:2. Bits 1:0 then become 00, which is kernel mode with interrupts disabled.
- R4: A return-from-exception strobe without a trap in the same cycle copies status bits 5:2 into bits 3:0. Bits 5:4 keep their value.
- R5: In a trap cycle `trapTaken` is 1 and `trapVector` is 0x80000080. At the next edge the return-address register takes `curPc`, and cause bits 6:2 take the trap code. For a request on `excReq`, which includes a system call with code 8, the trap code is `excCode`.
- R6: The bad-address register loads `badAddr` only on an `excReq` cycle with `badAddrValid` set, and otherwise holds its value. A write with select 3 never changes it and never traps, in either mode.
- R7: Cause bits 10+i are pending flags. A flag sets one cycle after line i is high and stays set. A kernel write to the cause register (select 1) clears each flag whose data bit 10+i is 1, and a line that is high in that cycle keeps its flag set.
- R8: An interrupt trap, with code 0, is taken in a cycle only when status bit 0 is 1 and some pending flag has its mask bit set.
- R9: In user mode, a write to status (select 0), cause (select 1) or return address (select 2) changes none of them. It causes a trap with code 10 instead.
- R10: A kernel write to status loads bits 5:0 and the mask field. A kernel write to the return-address register loads all bits. All other bits of status and cause are read-only zeros or hardware-owned.
- R11: Only one action happens per cycle, in this order of priority: `excReq`, then an illegal user write, then an interrupt, then return-from-exception, then a kernel write. An action that loses is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excReq | input | 1 | Synchronous exception or system call request |
| excCode | input | 5 | Type code of the requested exception |
| badAddrValid | input | 1 | `badAddr` carries a faulting data address |
| badAddr | input | XLEN | Faulting data address |
| curPc | input | XLEN | Address of the instruction in flight |
| irqLines | input | NUM_IRQ | Hardware interrupt lines |
| retStrobe | input | 1 | Return-from-exception |
| regWe | input | 1 | Privileged register write strobe |
| regSel | input | 2 | Write target: 0 status, 1 cause, 2 return address, 3 bad address |
| regWdata | input | XLEN | Write data |
| kernelMode | output | 1 | Current mode is kernel |
| trapTaken | output | 1 | A trap is taken this cycle |
| trapVector | output | XLEN | Handler address |
| statusOut | output | XLEN | Status register |
| causeOut | output | XLEN | Cause register |
| epcOut | output | XLEN | Return-address register |
| badAddrOut | output | XLEN | Bad-address register |

## Verification
The bench builds the unit with its default values: 32-bit registers and five interrupt lines. Because the stack field is only six bits wide, every one of its 64 values is loaded, and each one is checked for both a push and a direct pop. With five lines, the bench can also sweep every pairing of mask value and pending pattern (32 by 31) and compare the interrupt decision against an arithmetic AND of the two. Directed cases then cover user-mode refusal, pending-flag clearing against a live line, and the priority ordering.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int STACK_W  = 6;
  localparam int CODE_W   = 5;
  localparam int CODE_LSB = 2;
  localparam int IRQ_LSB  = 10;

  localparam logic [CODE_W-1:0] CODE_IRQ     = 5'd0;
  localparam logic [CODE_W-1:0] CODE_ILLEGAL = 5'd10;

  typedef enum logic [1:0] {
    SEL_STATUS  = 2'd0,
    SEL_CAUSE   = 2'd1,
    SEL_EPC     = 2'd2,
    SEL_BADADDR = 2'd3
  } regSel_e;

  typedef struct packed {
    logic              push;
    logic              pop;
    logic              capEpc;
    logic              capBad;
    logic              wrStatus;
    logic              wrEpc;
    logic              clrPend;
    logic [CODE_W-1:0] code;
  } ctrlStrobe_t;
endpackage

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int NUM_IRQ = 5
) (
  input  logic               excReq,
  input  logic [CODE_W-1:0]  excCode,
  input  logic               badAddrValid,
  input  logic               retStrobe,
  input  logic               regWe,
  input  logic [1:0]         regSel,
  input  logic               curIe,
  input  logic               curUser,
  input  logic [NUM_IRQ-1:0] pendMasked,
  output ctrlStrobe_t        strobe,
  output logic               trapTaken
);
  logic privSel;
  logic illegalWr;
  logic irqTake;

  // R9: status, cause and return address are privileged targets
  assign privSel   = (regSel != SEL_BADADDR);
  assign illegalWr = regWe && curUser && privSel;
  // R8: interrupt needs enable and an unmasked pending level
  assign irqTake   = curIe && (|pendMasked);

  // R11: one action per cycle, fixed priority
  always_comb begin
    strobe    = '0;
    trapTaken = 1'b0;
    if (excReq) begin
      trapTaken     = 1'b1;
      strobe.code   = excCode;
      strobe.capBad = badAddrValid;
    end else if (illegalWr) begin
      trapTaken   = 1'b1;
      strobe.code = CODE_ILLEGAL;
    end else if (irqTake) begin
      trapTaken   = 1'b1;
      strobe.code = CODE_IRQ;
    end else if (retStrobe) begin
      strobe.pop = 1'b1;
    end else if (regWe) begin
      strobe.wrStatus = (regSel == SEL_STATUS);
      strobe.clrPend  = (regSel == SEL_CAUSE);
      strobe.wrEpc    = (regSel == SEL_EPC);
    end
    strobe.push   = trapTaken;
    strobe.capEpc = trapTaken;
  end
endmodule

// File: rtl/exc_regs.sv
module exc_regs
  import exc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int NUM_IRQ = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [XLEN-1:0]    curPc,
  input  logic [XLEN-1:0]    badAddr,
  input  logic [NUM_IRQ-1:0] irqLines,
  input  logic [XLEN-1:0]    regWdata,
  output logic               curIe,
  output logic               curUser,
  output logic [NUM_IRQ-1:0] pendMasked,
  output logic [XLEN-1:0]    statusWord,
  output logic [XLEN-1:0]    causeWord,
  output logic [XLEN-1:0]    epcWord,
  output logic [XLEN-1:0]    badWord
);
  logic [STACK_W-1:0] stackQ, stackD;
  logic [NUM_IRQ-1:0] maskQ, maskD;
  logic [NUM_IRQ-1:0] pendQ;
  logic [CODE_W-1:0]  codeQ;
  logic [XLEN-1:0]    epcQ, badQ;

  // R3 push, R4 pop (old pair kept), R10 kernel load
  always_comb begin
    stackD = stackQ;
    maskD  = maskQ;
    if (strobe.push) begin
      stackD = {stackQ[3:0], 2'b00};
    end else if (strobe.pop) begin
      stackD = {stackQ[5:4], stackQ[5:2]};
    end else if (strobe.wrStatus) begin
      stackD = regWdata[STACK_W-1:0];
      maskD  = regWdata[IRQ_LSB +: NUM_IRQ];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stackQ <= '0;
      maskQ  <= '0;
      codeQ  <= '0;
      epcQ   <= '0;
      badQ   <= '0;
    end else begin
      stackQ <= stackD;
      maskQ  <= maskD;
      if (strobe.capEpc) begin
        codeQ <= strobe.code;
        epcQ  <= curPc;
      end else if (strobe.wrEpc) begin
        epcQ <= regWdata;
      end
      if (strobe.capBad) badQ <= badAddr;
    end
  end

  // R7: one sticky flag per line; a live line wins over a clear
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_pend
    always_ff @(posedge clk) begin
      if (!rstN) pendQ[i] <= 1'b0;
      else       pendQ[i] <= irqLines[i] |
                             (pendQ[i] & ~(strobe.clrPend & regWdata[IRQ_LSB + i]));
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[STACK_W-1:0] = stackQ;
    statusWord[IRQ_LSB +: NUM_IRQ] = maskQ;
    causeWord = '0;
    causeWord[CODE_LSB +: CODE_W] = codeQ;
    causeWord[IRQ_LSB +: NUM_IRQ] = pendQ;
  end

  assign epcWord    = epcQ;
  assign badWord    = badQ;
  assign curIe      = stackQ[0];
  assign curUser    = stackQ[1];
  assign pendMasked = pendQ & maskQ;
endmodule

// File: rtl/exc_status_unit.sv
module exc_status_unit
  import exc_pkg::*;
#(
  parameter int              XLEN    = 32,
  parameter int              NUM_IRQ = 5,
  parameter logic [XLEN-1:0] VECTOR  = 32'h8000_0080
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               excReq,
  input  logic [4:0]         excCode,
  input  logic               badAddrValid,
  input  logic [XLEN-1:0]    badAddr,
  input  logic [XLEN-1:0]    curPc,
  input  logic [NUM_IRQ-1:0] irqLines,
  input  logic               retStrobe,
  input  logic               regWe,
  input  logic [1:0]         regSel,
  input  logic [XLEN-1:0]    regWdata,
  output logic               kernelMode,
  output logic               trapTaken,
  output logic [XLEN-1:0]    trapVector,
  output logic [XLEN-1:0]    statusOut,
  output logic [XLEN-1:0]    causeOut,
  output logic [XLEN-1:0]    epcOut,
  output logic [XLEN-1:0]    badAddrOut
);
  ctrlStrobe_t        strobe;
  logic               curIe;
  logic               curUser;
  logic [NUM_IRQ-1:0] pendMasked;

  exc_ctrl #(.NUM_IRQ(NUM_IRQ)) u_ctrl (
    .excReq       (excReq),
    .excCode      (excCode),
    .badAddrValid (badAddrValid),
    .retStrobe    (retStrobe),
    .regWe        (regWe),
    .regSel       (regSel),
    .curIe        (curIe),
    .curUser      (curUser),
    .pendMasked   (pendMasked),
    .strobe       (strobe),
    .trapTaken    (trapTaken)
  );

  exc_regs #(.XLEN(XLEN), .NUM_IRQ(NUM_IRQ)) u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .curPc      (curPc),
    .badAddr    (badAddr),
    .irqLines   (irqLines),
    .regWdata   (regWdata),
    .curIe      (curIe),
    .curUser    (curUser),
    .pendMasked (pendMasked),
    .statusWord (statusOut),
    .causeWord  (causeOut),
    .epcWord    (epcOut),
    .badWord    (badAddrOut)
  );

  assign kernelMode = ~curUser;   // R2
  assign trapVector = VECTOR;     // R5
endmodule

// File: rtl/exc_status_checker.sv
module exc_status_checker #(
  parameter int XLEN    = 32,
  parameter int NUM_IRQ = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               excReq,
  input logic [4:0]         excCode,
  input logic               badAddrValid,
  input logic [XLEN-1:0]    badAddr,
  input logic [XLEN-1:0]    curPc,
  input logic [NUM_IRQ-1:0] irqLines,
  input logic               retStrobe,
  input logic               regWe,
  input logic [1:0]         regSel,
  input logic               kernelMode,
  input logic               trapTaken,
  input logic [XLEN-1:0]    statusOut,
  input logic [XLEN-1:0]    causeOut,
  input logic [XLEN-1:0]    epcOut,
  input logic [XLEN-1:0]    badAddrOut
);
  localparam int IRQ_LSB = 10;

  assert_push_R3: assert property (@(posedge clk) disable iff (!rstN)
    trapTaken |=> (statusOut[5:2] == $past(statusOut[3:0])) && (statusOut[1:0] == 2'b00) && kernelMode);

  assert_pop_R4: assert property (@(posedge clk) disable iff (!rstN)
    (retStrobe && !trapTaken) |=> (statusOut[3:0] == $past(statusOut[5:2])) &&
                                  (statusOut[5:4] == $past(statusOut[5:4])));

  assert_epc_R5: assert property (@(posedge clk) disable iff (!rstN)
    trapTaken |=> epcOut == $past(curPc));

  assert_code_R5: assert property (@(posedge clk) disable iff (!rstN)
    excReq |=> causeOut[6:2] == $past(excCode));

  assert_badload_R6: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && badAddrValid) |=> badAddrOut == $past(badAddr));

  assert_badhold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(excReq && badAddrValid) |=> $stable(badAddrOut));

  assert_pending_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|irqLines) |=> ((causeOut[IRQ_LSB +: NUM_IRQ] & $past(irqLines)) == $past(irqLines)));

  assert_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (trapTaken && !excReq && !regWe) |->
      (statusOut[0] && |(statusOut[IRQ_LSB +: NUM_IRQ] & causeOut[IRQ_LSB +: NUM_IRQ])));

  assert_illegal_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && !kernelMode && regSel != 2'd3 && !excReq) |-> trapTaken ##1 (causeOut[6:2] == 5'd10));
endmodule

bind exc_status_unit exc_status_checker #(.XLEN(XLEN), .NUM_IRQ(NUM_IRQ)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .excReq       (excReq),
  .excCode      (excCode),
  .badAddrValid (badAddrValid),
  .badAddr      (badAddr),
  .curPc        (curPc),
  .irqLines     (irqLines),
  .retStrobe    (retStrobe),
  .regWe        (regWe),
  .regSel       (regSel),
  .kernelMode   (kernelMode),
  .trapTaken    (trapTaken),
  .statusOut    (statusOut),
  .causeOut     (causeOut),
  .epcOut       (epcOut),
  .badAddrOut   (badAddrOut)
);

// File: tb/exc_status_unit_test.sv
`timescale 1ns/1ps
module exc_status_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        excReq = 1'b0;
  logic [4:0]  excCode = '0;
  logic        badAddrValid = 1'b0;
  logic [31:0] badAddr = '0;
  logic [31:0] curPc = '0;
  logic [4:0]  irqLines = '0;
  logic        retStrobe = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regSel = '0;
  logic [31:0] regWdata = '0;
  logic        kernelMode, trapTaken;
  logic [31:0] trapVector, statusOut, causeOut, epcOut, badAddrOut;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  exc_status_unit uut (
    .clk(clk), .rstN(rstN), .excReq(excReq), .excCode(excCode),
    .badAddrValid(badAddrValid), .badAddr(badAddr), .curPc(curPc),
    .irqLines(irqLines), .retStrobe(retStrobe), .regWe(regWe),
    .regSel(regSel), .regWdata(regWdata), .kernelMode(kernelMode),
    .trapTaken(trapTaken), .trapVector(trapVector), .statusOut(statusOut),
    .causeOut(causeOut), .epcOut(epcOut), .badAddrOut(badAddrOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    excReq = 0; badAddrValid = 0; retStrobe = 0; regWe = 0; irqLines = '0;
  endtask

  task automatic doReset();
    idle();
    rstN = 0;
    step(); step();
    rstN = 1;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    regWe = 1; regSel = sel; regWdata = d;
    step();
    regWe = 0;
  endtask

  task automatic trap(input logic [4:0] c, input logic [31:0] pc);
    excReq = 1; excCode = c; curPc = pc;
    step();
    excReq = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    doReset();
    // R1 reset state
    check("R1 status", statusOut, 32'h0);
    check("R1 cause", causeOut, 32'h0);
    check("R1 epc", epcOut, 32'h0);
    check("R1 bad", badAddrOut, 32'h0);
    check("R1 kernel", {31'b0, kernelMode}, 32'h1);

    // R2 R3 R4 R5 R10: every stack value, push then pop, and direct pop
    for (int v = 0; v < 64; v++) begin
      logic [5:0] s;
      logic [5:0] p;
      s = v[5:0];
      trap(5'd8, 32'h100);
      wr(2'd0, {26'b0, s});
      check("R10 status load", statusOut, {26'b0, s});
      check("R2 mode bit", {31'b0, kernelMode}, {31'b0, ~s[1]});
      excReq = 1; excCode = 5'd8; curPc = 32'h2000 + v;
      #1;
      check("R5 trapTaken", {31'b0, trapTaken}, 32'h1);
      check("R5 vector", trapVector, 32'h8000_0080);
      step();
      excReq = 0;
      p = {s[3:0], 2'b00};
      check("R3 push", statusOut, {26'b0, p});
      check("R5 epc", epcOut, 32'h2000 + v);
      check("R5 code", {27'b0, causeOut[6:2]}, 32'd8);
      retStrobe = 1; step(); retStrobe = 0;
      check("R4 pop after push", statusOut, {26'b0, p[5:4], p[5:2]});
      trap(5'd8, 32'h100);
      wr(2'd0, {26'b0, s});
      retStrobe = 1; step(); retStrobe = 0;
      check("R4 direct pop", statusOut, {26'b0, s[5:4], s[5:2]});
    end

    // R7 R8: every mask against every nonzero pending pattern
    for (int m = 0; m < 32; m++) begin
      for (int pp = 1; pp < 32; pp++) begin
        logic expTake;
        expTake = ((m & pp) != 0);
        doReset();
        wr(2'd0, (32'(m) << 10) | 32'h1);
        irqLines = pp[4:0];
        step();
        irqLines = '0;
        #1;
        check("R7 pending set", {27'b0, causeOut[14:10]}, 32'(pp));
        check("R8 irq decision", {31'b0, trapTaken}, {31'b0, expTake});
        step();
        check("R7 pending sticky", {27'b0, causeOut[14:10]}, 32'(pp));
        if (expTake) begin
          check("R8 irq code", {27'b0, causeOut[6:2]}, 32'd0);
          check("R8 irq push", {28'b0, statusOut[3:0]}, 32'h4);
        end else begin
          check("R8 no irq", {26'b0, statusOut[5:0]}, 32'h1);
        end
      end
    end

    // R8: disabled interrupts ignore pending lines
    doReset();
    wr(2'd0, 32'h1F << 10);
    irqLines = 5'h1F; step(); irqLines = '0;
    #1;
    check("R8 IE off no trap", {31'b0, trapTaken}, 32'h0);
    step();
    check("R8 IE off status", statusOut, 32'h1F << 10);

    // R7: clear with write-one, line high wins
    wr(2'd1, (32'h5 << 10));
    check("R7 clear", {27'b0, causeOut[14:10]}, 32'h1A);
    irqLines = 5'h1;
    wr(2'd1, (32'h3 << 10));
    irqLines = '0;
    check("R7 set wins", {27'b0, causeOut[14:10]}, 32'h19);

    // R9: user writes refused
    doReset();
    wr(2'd2, 32'h0000_0AAA);
    wr(2'd0, 32'h2);
    check("R2 user mode", {31'b0, kernelMode}, 32'h0);
    regWe = 1; regSel = 2'd2; regWdata = 32'hDEAD; curPc = 32'h400;
    #1;
    check("R9 trap on user write", {31'b0, trapTaken}, 32'h1);
    step(); regWe = 0;
    check("R9 epc not written", epcOut, 32'h400);
    check("R9 code", {27'b0, causeOut[6:2]}, 32'd10);
    check("R9 kernel after", {31'b0, kernelMode}, 32'h1);
    retStrobe = 1; step(); retStrobe = 0;
    check("R4 back to user", {31'b0, kernelMode}, 32'h0);
    curPc = 32'h404;
    wr(2'd0, 32'h0);
    check("R9 status not written", statusOut, 32'h8);
    retStrobe = 1; step(); retStrobe = 0;
    // R6: bad-address write ignored in user mode, no trap
    regWe = 1; regSel = 2'd3; regWdata = 32'hFFFF;
    #1;
    check("R6 no trap sel3", {31'b0, trapTaken}, 32'h0);
    step(); regWe = 0;
    check("R6 sel3 ignored", badAddrOut, 32'h0);

    // R6: bad address capture
    badAddrValid = 1; badAddr = 32'h1234;
    trap(5'd4, 32'h500);
    badAddrValid = 0; badAddr = 32'h9999;
    check("R6 bad latched", badAddrOut, 32'h1234);
    trap(5'd8, 32'h504);
    check("R6 bad held", badAddrOut, 32'h1234);
    wr(2'd3, 32'h7777);
    check("R6 kernel sel3 ignored", badAddrOut, 32'h1234);

    // R11: priority ordering
    doReset();
    irqLines = 5'h1; step(); irqLines = '0;
    wr(2'd0, (32'h1 << 10) | 32'h1);
    excReq = 1; excCode = 5'd4; curPc = 32'h600;
    step(); excReq = 0;
    check("R11 exc over irq", {27'b0, causeOut[6:2]}, 32'd4);
    // illegal write beats pending interrupt
    wr(2'd0, (32'h1 << 10) | 32'h3);
    curPc = 32'h700;
    wr(2'd2, 32'h55);
    check("R11 illegal over irq", {27'b0, causeOut[6:2]}, 32'd10);
    check("R11 illegal epc", epcOut, 32'h700);
    // return beats kernel write
    wr(2'd0, 32'h30);
    retStrobe = 1; regWe = 1; regSel = 2'd0; regWdata = 32'h0;
    step(); retStrobe = 0; regWe = 0;
    check("R11 pop over write", statusOut, 32'h3C);
    // exception beats return
    excReq = 1; excCode = 5'd8; retStrobe = 1; curPc = 32'h800;
    step(); excReq = 0; retStrobe = 0;
    check("R11 push over pop", {26'b0, statusOut[5:0]}, 32'h30);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule